// File: doc/BRIEF.md
# Pipelined Signed Carry-Save Multiplier Array

This block multiplies an 8-bit two's-complement data sample by a 12-bit two's-complement coefficient. It leaves the 20-bit product as two unresolved words, a sum word and a carry word. A following compressor or adder can merge them with other terms without paying for a carry-propagate stage here.

The array has one row of cells per data bit. Each cell ANDs one coefficient bit with one data bit and adds the result to the sum and carry bits coming down from the row above, so the AND and the full adder sit in one cell. Signed operands are handled with the modified Baugh-Wooley method. A partial-product bit that involves exactly one of the two sign bits is inverted. Three constant ones are added at bit positions 7, 11 and 19, and they enter the array as the initial sum word. Registers sit after every second row, which gives four pipeline stages. A valid strobe travels through the same four stages. Both operands travel with the partial result, so every row pair uses the operand bits of its own sample.

Top module: `bw_csa_mult`

## Requirements
- R1: When `out_vld` is high, (`out_sum` + `out_cry`) modulo 2^20 equals the signed product `in_data` × `in_coef` of the operands presented with `in_vld` high four clock edges earlier. Both operands are two's complement.
- R2: `out_vld` is high in exactly the cycle after the fourth rising edge following a cycle in which `in_vld` was sampled high, and low otherwise.
- R3: While `rst_n` is low at a rising edge, the following cycle shows `out_vld`, `out_sum` and `out_cry` all zero. Any operands in flight are discarded.
- R4: A new operand pair is accepted on every clock. Back-to-back pairs each produce their own correct product on consecutive cycles, without interference.
- R5: If either operand is zero, the merged output is exactly zero: the injected correction constants wrap out modulo 2^20.
- R6: The extreme operand values give exact products: −128 × −2048 = 262144, −128 × 2047 = −262016, 127 × −2048 = −260096 and 127 × 2047 = 259969.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Operand pair on the inputs is valid |
| in_data | input | 8 | Two's-complement data sample (multiplier, one array row per bit) |
| in_coef | input | 12 | Two's-complement coefficient (multiplicand) |
| out_vld | output | 1 | Sum and carry words are valid |
| out_sum | output | 20 | Sum word of the carry-save product |
| out_cry | output | 20 | Carry word of the carry-save product |

## Verification
Every result is due exactly four rising edges after the operands are sampled, one edge for each two-row stage. The bench keeps a queue of expected entries, each holding a valid flag, a product and a requirement tag. It primes the queue with four idle entries after each reset and pops one entry per clock. Outputs are compared at the falling edge, so the popped entry always belongs to the operands driven four cycles before. Reset checks are made one falling edge after a low `rst_n` has been sampled. The merged product is checked only in cycles whose popped entry is valid, while the valid flag is checked in every cycle.

// File: rtl/bw_pkg.sv
// Shared helpers for the signed carry-save multiplier array.
// Assumes nothing beyond constant integer arguments for the sizing function.
package bw_pkg;

    // Carry output of a full adder.
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    // Number of pipeline stages needed to cover all rows.
    function automatic int stage_count(input int rows, input int rows_per_stage);
        return (rows + rows_per_stage - 1) / rows_per_stage;
    endfunction

endpackage

// File: rtl/bw_pp_row.sv
// One row of gated full adders. The row forms the partial product of the
// whole multiplicand with a single multiplier bit, shifted by ROW places.
// Baugh-Wooley inversion is applied to bits that involve exactly one sign bit.
// The row merges that partial product with the incoming sum and carry words
// and produces a new carry-save pair. The carry out of the top bit is
// dropped, because all arithmetic is modulo 2^(A_W+B_W).
// Assumes: ROW < B_W, combinational only.
module bw_pp_row #(
    parameter int A_W = 12,
    parameter int B_W = 8,
    parameter int ROW = 0
) (
    input  logic [A_W-1:0]     a,
    input  logic               b_bit,
    input  logic [A_W+B_W-1:0] sum_in,
    input  logic [A_W+B_W-1:0] cry_in,
    output logic [A_W+B_W-1:0] sum_out,
    output logic [A_W+B_W-1:0] cry_out
);
    import bw_pkg::*;

    localparam int  P_W      = A_W + B_W;
    localparam bit  ROW_SIGN = (ROW == B_W - 1);

    logic [P_W-1:0] pp;
    logic [P_W-1:0] maj;

    // Gated partial-product bits with sign inversion, placed at ROW+j.
    always_comb begin
        pp = '0;
        for (int j = 0; j < A_W; j++) begin
            pp[ROW + j] = (a[j] & b_bit) ^ ((j == A_W - 1) != ROW_SIGN);
        end
    end

    // Bitwise full adders: sum stays in place, carry moves up one bit.
    always_comb begin
        for (int k = 0; k < P_W; k++) begin
            sum_out[k] = sum_in[k] ^ cry_in[k] ^ pp[k];
            maj[k]     = maj3(sum_in[k], cry_in[k], pp[k]);
        end
        cry_out = {maj[P_W-2:0], 1'b0};
    end

endmodule

// File: rtl/bw_stage.sv
// One pipeline stage: RPS consecutive rows of gated full adders followed by
// a register bank. The operands and the valid strobe are registered along
// with the partial carry-save result, so the next stage works on the same
// sample. Global row indices that reach past the last multiplier bit become
// wires. Assumes: synchronous active-low reset.
module bw_stage #(
    parameter int A_W = 12,
    parameter int B_W = 8,
    parameter int RPS = 2,
    parameter int STG = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vld_in,
    input  logic [A_W-1:0]     a_in,
    input  logic [B_W-1:0]     b_in,
    input  logic [A_W+B_W-1:0] sum_in,
    input  logic [A_W+B_W-1:0] cry_in,
    output logic               vld_q,
    output logic [A_W-1:0]     a_q,
    output logic [B_W-1:0]     b_q,
    output logic [A_W+B_W-1:0] sum_q,
    output logic [A_W+B_W-1:0] cry_q
);
    localparam int P_W = A_W + B_W;

    logic [RPS:0][P_W-1:0] s_ch;
    logic [RPS:0][P_W-1:0] c_ch;

    assign s_ch[0] = sum_in;
    assign c_ch[0] = cry_in;

    for (genvar r = 0; r < RPS; r++) begin : g_row
        localparam int GROW = STG * RPS + r;
        if (GROW < B_W) begin : g_cell
            bw_pp_row #(.A_W(A_W), .B_W(B_W), .ROW(GROW)) u_row (
                .a      (a_in),
                .b_bit  (b_in[GROW]),
                .sum_in (s_ch[r]),
                .cry_in (c_ch[r]),
                .sum_out(s_ch[r+1]),
                .cry_out(c_ch[r+1])
            );
        end else begin : g_pass
            assign s_ch[r+1] = s_ch[r];
            assign c_ch[r+1] = c_ch[r];
        end
    end

    // Stage register: capture the row-pair result together with its operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            a_q   <= '0;
            b_q   <= '0;
            sum_q <= '0;
            cry_q <= '0;
        end else begin
            vld_q <= vld_in;
            a_q   <= a_in;
            b_q   <= b_in;
            sum_q <= s_ch[RPS];
            cry_q <= c_ch[RPS];
        end
    end

    AST_VLD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (vld_q == $past(vld_in))); // R2

endmodule

// File: rtl/bw_csa_mult.sv
// Pipelined signed multiplier in carry-save form. The multiplier in_data
// drives one row per bit, the multiplicand is in_coef, and there is one
// register stage per RPS rows. The Baugh-Wooley correction constant enters
// as the initial sum word. out_sum + out_cry, modulo 2^(A_W+B_W), is the
// signed product. Assumes: A_W >= 2, B_W >= 2, synchronous active-low reset.
module bw_csa_mult #(
    parameter int A_W = 12,
    parameter int B_W = 8,
    parameter int RPS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld,
    input  logic [B_W-1:0]     in_data,
    input  logic [A_W-1:0]     in_coef,
    output logic               out_vld,
    output logic [A_W+B_W-1:0] out_sum,
    output logic [A_W+B_W-1:0] out_cry
);
    import bw_pkg::*;

    localparam int P_W = A_W + B_W;
    localparam int LAT = stage_count(B_W, RPS);
    localparam logic [P_W-1:0] CORR = (P_W'(1) << (B_W - 1))
                                    + (P_W'(1) << (A_W - 1))
                                    + (P_W'(1) << (P_W - 1));

    logic [LAT:0]          v_ch;
    logic [LAT:0][A_W-1:0] a_ch;
    logic [LAT:0][B_W-1:0] b_ch;
    logic [LAT:0][P_W-1:0] s_ch;
    logic [LAT:0][P_W-1:0] c_ch;

    // Stage-0 inputs: operands, and the correction constant as the sum word.
    assign v_ch[0] = in_vld;
    assign a_ch[0] = in_coef;
    assign b_ch[0] = in_data;
    assign s_ch[0] = CORR;
    assign c_ch[0] = '0;

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        bw_stage #(.A_W(A_W), .B_W(B_W), .RPS(RPS), .STG(g)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_in(v_ch[g]),
            .a_in  (a_ch[g]),
            .b_in  (b_ch[g]),
            .sum_in(s_ch[g]),
            .cry_in(c_ch[g]),
            .vld_q (v_ch[g+1]),
            .a_q   (a_ch[g+1]),
            .b_q   (b_ch[g+1]),
            .sum_q (s_ch[g+1]),
            .cry_q (c_ch[g+1])
        );
    end

    assign out_vld = v_ch[LAT];
    assign out_sum = s_ch[LAT];
    assign out_cry = c_ch[LAT];

    // Sign-extended operand copies used only by the checks below.
    logic signed [P_W-1:0] chk_data;
    logic signed [P_W-1:0] chk_coef;
    assign chk_data = P_W'($signed(in_data));
    assign chk_coef = P_W'($signed(in_coef));

    AST_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (P_W'(out_sum + out_cry) == P_W'($past(chk_data, LAT) * $past(chk_coef, LAT)))); // R1

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && ($past(in_data, LAT) == '0 || $past(in_coef, LAT) == '0)) |-> (P_W'(out_sum + out_cry) == '0)); // R5

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && out_sum == '0 && out_cry == '0)); // R3

endmodule

// File: tb/bw_csa_mult_tb.sv
// Self-checking bench: a behavioural queue model of the expected outputs,
// compared with the design on every falling clock edge.
module bw_csa_mult_tb;
    localparam int A_W = 12;
    localparam int B_W = 8;
    localparam int P_W = A_W + B_W;
    localparam int LAT = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_vld = 1'b0;
    logic [B_W-1:0] in_data = '0;
    logic [A_W-1:0] in_coef = '0;
    logic           out_vld;
    logic [P_W-1:0] out_sum;
    logic [P_W-1:0] out_cry;

    int checks = 0;
    int fails  = 0;

    logic           vq[$];
    logic [P_W-1:0] pq[$];
    string          tq[$];

    bw_csa_mult #(.A_W(A_W), .B_W(B_W), .RPS(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
        .in_coef(in_coef), .out_vld(out_vld), .out_sum(out_sum), .out_cry(out_cry)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic prime();
        vq.delete(); pq.delete(); tq.delete();
        for (int i = 0; i < LAT; i++) begin
            vq.push_back(1'b0); pq.push_back('0); tq.push_back("R2");
        end
    endtask

    // One clock: compare outputs with the oldest model entry, then drive new operands.
    task automatic step(input bit v, input int d, input int c, input string tag);
        logic           ev;
        logic [P_W-1:0] ep;
        logic [P_W-1:0] got;
        string          et;
        int             prod;
        @(negedge clk);
        ev = vq.pop_front(); ep = pq.pop_front(); et = tq.pop_front();
        check(out_vld == ev, "R2 valid timing", out_vld, ev);
        if (ev) begin
            got = out_sum + out_cry;
            check(got == ep, {et, " product"}, $signed(got), $signed(ep));
        end
        in_vld  = v;
        in_data = B_W'(d);
        in_coef = A_W'(c);
        prod = d * c;
        vq.push_back(v); pq.push_back(P_W'(prod)); tq.push_back(tag);
    endtask

    task automatic reset_and_check(input int cycles);
        @(negedge clk);
        rst_n  = 1'b0;
        in_vld = 1'b0;
        repeat (cycles) @(negedge clk);
        check(out_vld == 1'b0, "R3 out_vld", out_vld, 0);
        check(out_sum == '0, "R3 out_sum", out_sum, 0);
        check(out_cry == '0, "R3 out_cry", out_cry, 0);
        prime();
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int ext_d[4];
        int ext_c[4];
        ext_d = '{-128, -128, 127, 127};
        ext_c = '{-2048, 2047, -2048, 2047};

        reset_and_check(3);

        // R1: every data value with a random coefficient.
        for (int d = -128; d < 128; d++) begin
            step(1'b1, d, $signed(A_W'($urandom)), "R1");
        end

        // R6: extreme operand pairs.
        for (int i = 0; i < 4; i++) step(1'b1, ext_d[i], ext_c[i], "R6");

        // R5: zero in either operand, including extreme partners.
        step(1'b1, 0, -2048, "R5");
        step(1'b1, -128, 0, "R5");
        step(1'b1, 0, 0, "R5");
        step(1'b1, 127, 0, "R5");

        // R4: back-to-back pairs with alternating signs, every cycle.
        for (int i = 0; i < 64; i++) begin
            step(1'b1, (i % 2) ? -(i + 1) : (i + 60), (i % 2) ? (i * 31) : -(i * 29 + 1), "R4");
        end

        // R2: valid strobe with bubbles.
        for (int i = 0; i < 40; i++) begin
            step((i % 3) != 1, i * 5 - 100, 1000 - i * 47, "R2");
        end

        // R3: reset with the pipeline full discards everything in flight.
        for (int i = 0; i < 3; i++) step(1'b1, 11 + i, -7 - i, "R3");
        reset_and_check(2);
        for (int i = 0; i < 6; i++) step(1'b0, 0, 0, "R3");
        for (int i = 0; i < 8; i++) step(1'b1, -i * 9, 300 + i, "R1");

        // Drain.
        for (int i = 0; i < LAT + 1; i++) step(1'b0, 0, 0, "R2");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule